// File: doc/BRIEF.md
# Mixed-Scaling Fixed-Point Accumulator

This block sums three unsigned 8-bit fixed-point operands. Each operand has its own binary-point position. The result is an 8-bit word with three fractional bits, so an LSB weighs 1/8 and five integer bits remain. Every operand carries a fractional-bit count. On the clock edge that accepts a start pulse, the block latches all three operand words and their counts, and it clears the running sum and the overflow flag.

On each of the next three edges the block takes one operand, in the order operand 0, 1, 2. It aligns the operand to the output scaling by shifting it right by the surplus of fractional bits. The bits shifted out are dropped, which rounds toward floor. The aligned value is then added into the running sum. Because each operand is rounded before it is added, the final value can fall below the correctly rounded exact sum. For example, 19.875, 5.4375 and 4.84375 give 30.000 here instead of 30.125.

The interface is plain control. A start strobe begins a run and a done strobe marks its end. There is no valid/ready handshake and no back-pressure. The result is not consumed: `sum` keeps its value after done until the next accepted start, so a reader may sample it in the done cycle or in any later cycle.

Top module: `mxacc_top`

## Requirements
- R1: `sum` is unsigned with three fractional bits (value = sum/8). Operand i sits in bits [8i+7:8i] of `op_word`, and its 3-bit fractional-bit count sits in bits [3i+2:3i] of `op_frac`.
- R2: An operand with f > 3 fractional bits is shifted right by f-3 before it is added. The discarded bits are dropped (floor rounding).
- R3: An operand whose fractional-bit count is below 3 is added without any shift, as if its count were 3.
- R4: On the edge that accepts a start, `sum` becomes 0 and `overflow` becomes 0.
- R5: Operands 0, 1 and 2 are added on the first, second and third edges after the accepting edge. Each partial sum is visible on `sum` in the cycle that follows its edge.
- R6: `done` is high for exactly one cycle, in the cycle after the third addition, while `sum` holds the final result. `sum` then holds that value until the next accepted start.
- R7: An addition that carries out of bit 7 wraps `sum` modulo 256 and sets `overflow`. The flag stays set until the next accepted start, even if later additions do not carry.
- R8: A start pulse that arrives during an accumulation (on the accepting edge's following three edges) is ignored.
- R9: Operand words and counts are captured on the accepting edge. Input changes after that edge do not affect the run.
- R10: After reset, `sum` is 0, `done` is 0 and `overflow` is 0.
- R11: The inputs 159/3, 87/4, 155/5 (19.875, 5.4375, 4.84375) produce partial sums 159 and 202 and a final value of 240 (30.000), not 241.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Begin an accumulation; accepted only when idle |
| op_word | input | 24 | Three packed operand words, operand 0 in the low byte |
| op_frac | input | 9 | Three packed 3-bit fractional-bit counts |
| sum | output | 8 | Running or final sum, 3 fractional bits |
| done | output | 1 | One-cycle pulse when the final sum is on `sum` |
| overflow | output | 1 | Sticky carry-out flag for the current run |

## Verification
The hardest cases to reach are a start that arrives in the middle of a run and an overflow on one step followed by a step that does not carry.

For the first, the bench raises `start` on a chosen cycle between acceptance and done. At the same time it puts different operands on the inputs. It then checks that every partial sum and the done timing still follow the original run.

For the second, the vector table contains operand sets whose carry happens on the second or third addition. One of these is followed by a non-carrying add. Another run is placed after an overflowing one, so the check also shows that the flag is cleared by the next start.

// File: rtl/mxacc_pkg.sv
package mxacc_pkg;
  localparam int unsigned WORD_W   = 8;
  localparam int unsigned OUT_FRAC = 3;
  localparam int unsigned FRAC_W   = 3;
  localparam int unsigned NUM_OPS  = 3;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mxacc_lane.sv
module mxacc_lane #(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned FRAC_W   = 3,
  parameter int unsigned OUT_FRAC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [WORD_W-1:0] aligned
);
  localparam logic [FRAC_W-1:0] OUT_F = FRAC_W'(OUT_FRAC);

  logic [WORD_W-1:0] word_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] shamt;

  // Latch the operand on the accepting edge (R9)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      frac_q <= '0;
    end else if (load) begin
      word_q <= word_in;
      frac_q <= frac_in;
    end
  end

  // Surplus fraction bits; counts at or below the output format do not shift (R3)
  always_comb begin
    if (frac_q > OUT_F) shamt = frac_q - OUT_F;
    else                shamt = '0;
  end

  // Unsigned right shift drops the low bits: floor rounding (R2)
  assign aligned = word_q >> shamt;
endmodule

// File: rtl/mxacc_seq.sv
module mxacc_seq #(
  parameter int unsigned NUM_OPS = 3,
  parameter int unsigned IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_OPS - 1);

  logic last_step;

  assign accept    = start && !busy;
  assign last_step = busy && (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      done <= 1'b0;
    end else begin
      done <= last_step;
      if (accept) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (last_step) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  // R6: done never lasts beyond one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a start seen mid-run does not rewind the step counter
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (done || (idx == $past(idx) + IDX_W'(1))));
endmodule

// File: rtl/mxacc_core.sv
module mxacc_core #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add_en,
  input  logic [WORD_W-1:0] addend,
  output logic [WORD_W-1:0] acc,
  output logic              ovf
);
  logic [WORD_W:0] wide_sum;

  assign wide_sum = {1'b0, acc} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (clear) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (add_en) begin
      acc <= wide_sum[WORD_W-1:0];
      if (wide_sum[WORD_W]) ovf <= 1'b1;
    end
  end

  // R4: a clear leaves zero sum and no overflow
  a_r4_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0) && !ovf);

  // R7: once set the flag survives until a clear
  a_r7_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clear) |=> ovf);

  // R7: an addition past full scale raises the flag
  a_r7_carry_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !clear && (({1'b0, acc} + {1'b0, addend}) > {1'b0, {WORD_W{1'b1}}})) |=> ovf);

  // R6: outside a run the sum does not move
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_en && !clear) |=> $stable(acc));
endmodule

// File: rtl/mxacc_top.sv
module mxacc_top
  import mxacc_pkg::*;
#(
  parameter int unsigned P_WORD_W   = WORD_W,
  parameter int unsigned P_FRAC_W   = FRAC_W,
  parameter int unsigned P_OUT_FRAC = OUT_FRAC,
  parameter int unsigned P_NUM_OPS  = NUM_OPS
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [P_NUM_OPS-1:0][P_WORD_W-1:0] op_word,
  input  logic [P_NUM_OPS-1:0][P_FRAC_W-1:0] op_frac,
  output logic [P_WORD_W-1:0]                sum,
  output logic                               done,
  output logic                               overflow
);
  localparam int unsigned IDX_W = idx_width(P_NUM_OPS);

  logic                accept;
  logic                busy;
  logic [IDX_W-1:0]    idx;
  logic [P_WORD_W-1:0] aligned [P_NUM_OPS];
  logic [P_WORD_W-1:0] addend;

  mxacc_seq #(
    .NUM_OPS (P_NUM_OPS),
    .IDX_W   (IDX_W)
  ) seq_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .busy   (busy),
    .idx    (idx),
    .done   (done)
  );

  for (genvar g = 0; g < P_NUM_OPS; g++) begin : g_lane
    mxacc_lane #(
      .WORD_W   (P_WORD_W),
      .FRAC_W   (P_FRAC_W),
      .OUT_FRAC (P_OUT_FRAC)
    ) lane_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .word_in (op_word[g]),
      .frac_in (op_frac[g]),
      .aligned (aligned[g])
    );
  end

  // Pick the lane for the current step (R5 ordering)
  always_comb begin
    addend = '0;
    for (int i = 0; i < P_NUM_OPS; i++) begin
      if (idx == IDX_W'(i)) addend = aligned[i];
    end
  end

  mxacc_core #(
    .WORD_W (P_WORD_W)
  ) core_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .add_en (busy),
    .addend (addend),
    .acc    (sum),
    .ovf    (overflow)
  );
endmodule

// File: tb/mxacc_top_tb_top.sv
`timescale 1ns/1ps
module mxacc_top_tb_top;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [2:0][7:0] op_word = '0;
  logic [2:0][2:0] op_frac = '0;
  logic [7:0]      sum;
  logic            done;
  logic            overflow;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  mxacc_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_word  (op_word),
    .op_frac  (op_frac),
    .sum      (sum),
    .done     (done),
    .overflow (overflow)
  );

  typedef struct packed {
    logic [7:0] a, b, c;
    logic [2:0] fa, fb, fc;
    logic [7:0] exp_sum;
    logic       exp_ovf;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd159, 8'd87,  8'd155, 3'd3, 3'd4, 3'd5, 8'd240, 1'b0}, // R11 reference
    '{8'd255, 8'd255, 8'd1,   3'd3, 3'd3, 3'd3, 8'd255, 1'b1}, // R7 carry then no carry
    '{8'd200, 8'd200, 8'd100, 3'd3, 3'd3, 3'd6, 8'd156, 1'b1}, // R7 wrap, R2 shift 3
    '{8'd10,  8'd7,   8'd0,   3'd7, 3'd4, 3'd3, 8'd3,   1'b0}, // R2 floor to 0, R4 flag cleared
    '{8'd50,  8'd20,  8'd8,   3'd1, 3'd0, 3'd3, 8'd78,  1'b0}, // R3 small counts
    '{8'd128, 8'd127, 8'd1,   3'd3, 3'd3, 3'd3, 8'd0,   1'b1}, // R7 carry on third add
    '{8'd255, 8'd255, 8'd255, 3'd7, 3'd6, 3'd5, 8'd109, 1'b0}  // R2 shifts 4,3,2
  };

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive start with operands; returns at the negedge after the accepting edge
  task automatic launch(input logic [7:0] a, b, c, input logic [2:0] fa, fb, fc);
    @(negedge clk);
    op_word = {c, b, a};
    op_frac = {fc, fb, fa};
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R10 reset state, with start held during reset
    start = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 sum", sum, 0);
    chk("R10 done", done, 0);
    chk("R10 overflow", overflow, 0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after release", done, 0);

    // Table-driven runs
    for (int v = 0; v < NV; v++) begin
      launch(VECS[v].a, VECS[v].b, VECS[v].c, VECS[v].fa, VECS[v].fb, VECS[v].fc);
      chk("R4 sum cleared", sum, 0);
      chk("R4 overflow cleared", overflow, 0);
      repeat (2) @(negedge clk);
      chk("R6 no early done", done, 0);
      @(negedge clk);
      chk("R6 done pulse", done, 1);
      chk("R1 R2 R3 final sum", sum, VECS[v].exp_sum);
      chk("R7 overflow", overflow, VECS[v].exp_ovf);
      @(negedge clk);
      chk("R6 done one cycle", done, 0);
      chk("R6 sum held", sum, VECS[v].exp_sum);
    end

    // R5 R11 partial sums, with R9 input change and R8 mid-run start
    launch(8'd159, 8'd87, 8'd155, 3'd3, 3'd4, 3'd5);
    op_word = {8'd1, 8'd1, 8'd1};
    op_frac = {3'd3, 3'd3, 3'd3};
    @(negedge clk);
    chk("R5 R11 first partial", sum, 159);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5 R11 second partial", sum, 202);
    chk("R8 no restart", done, 0);
    @(negedge clk);
    chk("R8 R9 done on time", done, 1);
    chk("R9 R11 final unaffected", sum, 240);
    @(negedge clk);
    chk("R8 no second run", done, 0);
    repeat (3) @(negedge clk);
    chk("R8 still idle", done, 0);
    chk("R6 sum kept", sum, 240);

    // R7 flag survives a later non-carry add, cleared by next start
    launch(8'd255, 8'd2, 8'd0, 3'd3, 3'd3, 3'd3);
    @(negedge clk);
    chk("R7 no carry yet", overflow, 0);
    @(negedge clk);
    chk("R7 carry sets flag", overflow, 1);
    chk("R7 wrapped value", sum, 1);
    @(negedge clk);
    chk("R7 flag sticky", overflow, 1);
    launch(8'd1, 8'd1, 8'd1, 3'd3, 3'd3, 3'd3);
    chk("R4 R7 flag cleared", overflow, 0);
    repeat (3) @(negedge clk);
    chk("R5 three adds", sum, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule